// File: doc/BRIEF.md
# Window Watchdog and Reset Generator

This block supervises an external controller and owns its active-low reset line. When the supply-good flag rises, the reset is held low for a power-on delay and then released. The controller then gets one long lead phase to deliver its first trigger. After that, every trigger starts a closed window, in which a trigger is a fault. The closed window is followed by an open window, in which the next trigger must arrive. A trigger is the falling edge of an active-low input. It counts only once the input has stayed low for a minimum number of clock cycles.

When a trigger is early or missing, the block drives a fixed-length reset pulse and raises a one-cycle flag. The mode controller uses this flag to tell a watchdog fault apart from an undervoltage reset. After the pulse, supervision starts again from the lead phase. All delays and windows are parameters counted in ticks of a slow timebase strobe. A mode-disable input turns the watchdog off, and a run input from the mode controller halts it in low-power modes. Losing supply-good forces reset low at any time.

Top module: `wwdg_rstgen`

## Requirements
- R1: After `supply_ok_i` rises, `rst_n_o` stays low until the POR_TICKS-th tick, counted from that point. It goes high in the same clock as that tick is sampled.
- R2: While `supply_ok_i` is low, `rst_n_o` is low from the following clock edge onward and `wd_bite_o` stays low. Watchdog state is ignored.
- R3: If no trigger arrives within LEAD_TICKS ticks after the lead phase begins, a watchdog reset is issued on the LEAD_TICKS-th tick.
- R4: A trigger accepted while the closed window (CLOSED_TICKS ticks after a trigger) is running issues a watchdog reset.
- R5: A trigger during the open window (OPEN_TICKS ticks after the closed window) restarts the closed window without any reset. If no trigger arrives, a watchdog reset is issued on the OPEN_TICKS-th tick of the open window.
- R6: A watchdog reset holds `rst_n_o` low for exactly PULSE_TICKS ticks and then starts a full new lead phase. Triggers during the pulse are ignored.
- R7: Every watchdog reset raises `wd_bite_o` for exactly one clock, in the same clock in which `rst_n_o` first goes low.
- R8: A low level on `kick_n_i` lasting at least MIN_LOW_CYC clocks is one trigger. A shorter low level is ignored.
- R9: While `wd_run_i` is low, no watchdog reset occurs and the block parks in the lead phase. When `wd_run_i` returns high, a full lead phase is granted.
- R10: While `wd_off_i` is high, no watchdog reset occurs, whatever happens on `kick_n_i`. When `wd_off_i` is cleared, a full lead phase starts.
- R11: During and right after `rst`, `rst_n_o` is low and `wd_bite_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-clock strobe of the slow timebase |
| kick_n_i | input | 1 | Active-low trigger from the supervised controller (asynchronous) |
| supply_ok_i | input | 1 | Supply above its undervoltage threshold |
| wd_off_i | input | 1 | High switches the watchdog off |
| wd_run_i | input | 1 | Low halts the watchdog (low-power modes) |
| rst_n_o | output | 1 | Active-low reset to the controller |
| wd_bite_o | output | 1 | One-clock flag marking a watchdog-caused reset |

## Verification
The bench places triggers at random positions inside the lead phase and the open window. It also aims triggers at the last tick of the closed window, where a design that swapped the window order or miscounted by one tick would miss the early-trigger fault. Pulses one clock shorter than the minimum width, and triggers sent during a reset pulse, must leave the sequence untouched. A filter or pulse phase that let them through would cut the next lead phase short, and the bench catches this by the exact tick on which the following reset falls. Halting and disabling are entered from the closed and open windows. A design that froze its counter instead of restarting it would then fire before the full lead time the bench expects. Supply loss in the open window must drop the reset with no watchdog flag.

// File: rtl/wwdg_pkg.sv
package wwdg_pkg;

  typedef enum logic [2:0] {
    PH_UNDERVOLT = 3'd0,
    PH_POR_HOLD  = 3'd1,
    PH_LEAD      = 3'd2,
    PH_CLOSED    = 3'd3,
    PH_OPEN      = 3'd4,
    PH_BITE      = 3'd5
  } wd_phase_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Phases in which the controller runs out of reset
  function automatic logic releases_reset(input wd_phase_e p);
    return (p == PH_LEAD) || (p == PH_CLOSED) || (p == PH_OPEN);
  endfunction

endpackage

// File: rtl/wwdg_kick_filter.sv
module wwdg_kick_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW_CYC = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic kick_n_i,
  output logic kick_o
);
  localparam int LW = $clog2(MIN_LOW_CYC + 1);
  localparam logic [LW-1:0] FIRE_AT = LW'(MIN_LOW_CYC - 1);
  localparam logic [LW-1:0] SAT_AT  = LW'(MIN_LOW_CYC);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lvl;
  logic [LW-1:0]          low_q;
  logic                   kick_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= kick_n_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], kick_n_i};
      end
    end
  endgenerate

  assign lvl = sync_q[SYNC_STAGES-1];

  // Count low cycles, saturate so a long hold yields a single trigger
  always_ff @(posedge clk) begin
    if (rst) begin
      low_q  <= '0;
      kick_q <= 1'b0;
    end else begin
      kick_q <= !lvl && (low_q == FIRE_AT);
      if (lvl)                low_q <= '0;
      else if (low_q != SAT_AT) low_q <= low_q + 1'b1;
    end
  end

  assign kick_o = kick_q;

  // R8
  single_kick_chk: assert property (@(posedge clk) disable iff (rst)
    kick_q |=> !kick_q);

endmodule

// File: rtl/wwdg_tick_timer.sv
module wwdg_tick_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = tick_i && (cnt_q == limit_i - 1'b1);

  always_ff @(posedge clk) begin
    if (rst)            cnt_q <= '0;
    else if (clr_i)     cnt_q <= '0;
    else if (expire_o)  cnt_q <= '0;
    else if (tick_i)    cnt_q <= cnt_q + 1'b1;
  end

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q < limit_i);

endmodule

// File: rtl/wwdg_seq.sv
module wwdg_seq
  import wwdg_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int POR_TICKS    = 4,
  parameter int LEAD_TICKS   = 155,
  parameter int CLOSED_TICKS = 20,
  parameter int OPEN_TICKS   = 21,
  parameter int PULSE_TICKS  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             supply_ok_i,
  input  logic             active_i,
  input  logic             kick_i,
  input  logic             expire_i,
  output wd_phase_e        state_q_o,
  output wd_phase_e        state_d_o,
  output logic [CNT_W-1:0] limit_o,
  output logic             clr_o
);
  localparam logic [CNT_W-1:0] L_POR    = CNT_W'(POR_TICKS);
  localparam logic [CNT_W-1:0] L_LEAD   = CNT_W'(LEAD_TICKS);
  localparam logic [CNT_W-1:0] L_CLOSED = CNT_W'(CLOSED_TICKS);
  localparam logic [CNT_W-1:0] L_OPEN   = CNT_W'(OPEN_TICKS);
  localparam logic [CNT_W-1:0] L_PULSE  = CNT_W'(PULSE_TICKS);

  wd_phase_e state_q, state_d;
  logic      park;

  always_comb begin
    unique case (state_q)
      PH_POR_HOLD: limit_o = L_POR;
      PH_LEAD:     limit_o = L_LEAD;
      PH_CLOSED:   limit_o = L_CLOSED;
      PH_OPEN:     limit_o = L_OPEN;
      PH_BITE:     limit_o = L_PULSE;
      default:     limit_o = CNT_W'(1);
    endcase
  end

  always_comb begin
    state_d = state_q;
    park    = 1'b0;
    unique case (state_q)
      PH_UNDERVOLT: if (supply_ok_i) state_d = PH_POR_HOLD;
      PH_POR_HOLD:  if (expire_i)    state_d = PH_LEAD;
      PH_LEAD: begin
        if (!active_i)     park    = 1'b1;
        else if (kick_i)   state_d = PH_CLOSED;
        else if (expire_i) state_d = PH_BITE;
      end
      PH_CLOSED: begin
        if (!active_i)     state_d = PH_LEAD;
        else if (kick_i)   state_d = PH_BITE;
        else if (expire_i) state_d = PH_OPEN;
      end
      PH_OPEN: begin
        if (!active_i)     state_d = PH_LEAD;
        else if (kick_i)   state_d = PH_CLOSED;
        else if (expire_i) state_d = PH_BITE;
      end
      PH_BITE:      if (expire_i)    state_d = PH_LEAD;
      default:      state_d = PH_UNDERVOLT;
    endcase
    if (!supply_ok_i) state_d = PH_UNDERVOLT;
  end

  assign clr_o = park || (state_d != state_q);

  always_ff @(posedge clk) begin
    if (rst) state_q <= PH_UNDERVOLT;
    else     state_q <= state_d;
  end

  assign state_q_o = state_q;
  assign state_d_o = state_d;

  // R4
  early_kick_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == PH_CLOSED && kick_i && active_i && supply_ok_i) |=> state_q == PH_BITE);

  // R5
  open_expiry_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == PH_OPEN && expire_i && !kick_i && active_i && supply_ok_i) |=> state_q == PH_BITE);

  // R9
  halt_park_chk: assert property (@(posedge clk) disable iff (rst)
    (!active_i && supply_ok_i && (state_q == PH_LEAD || state_q == PH_CLOSED || state_q == PH_OPEN))
      |=> state_q == PH_LEAD);

endmodule

// File: rtl/wwdg_rstgen.sv
module wwdg_rstgen
  import wwdg_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int MIN_LOW_CYC  = 20,
  parameter int POR_TICKS    = 4,
  parameter int LEAD_TICKS   = 155,
  parameter int CLOSED_TICKS = 20,
  parameter int OPEN_TICKS   = 21,
  parameter int PULSE_TICKS  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic kick_n_i,
  input  logic supply_ok_i,
  input  logic wd_off_i,
  input  logic wd_run_i,
  output logic rst_n_o,
  output logic wd_bite_o
);
  localparam int MAX_T = max_of(max_of(max_of(POR_TICKS, LEAD_TICKS),
                                       max_of(CLOSED_TICKS, OPEN_TICKS)), PULSE_TICKS);
  localparam int CNT_W = $clog2(MAX_T + 1);

  logic             kick;
  logic             expire;
  logic             clr;
  logic             active;
  logic [CNT_W-1:0] limit;
  wd_phase_e        state_q, state_d;
  logic             rst_n_q, bite_q;

  assign active = wd_run_i && !wd_off_i;

  wwdg_kick_filter #(
    .SYNC_STAGES (SYNC_STAGES),
    .MIN_LOW_CYC (MIN_LOW_CYC)
  ) u_filter (
    .clk      (clk),
    .rst      (rst),
    .kick_n_i (kick_n_i),
    .kick_o   (kick)
  );

  wwdg_tick_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick_i),
    .clr_i    (clr),
    .limit_i  (limit),
    .expire_o (expire)
  );

  wwdg_seq #(
    .CNT_W        (CNT_W),
    .POR_TICKS    (POR_TICKS),
    .LEAD_TICKS   (LEAD_TICKS),
    .CLOSED_TICKS (CLOSED_TICKS),
    .OPEN_TICKS   (OPEN_TICKS),
    .PULSE_TICKS  (PULSE_TICKS)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .supply_ok_i (supply_ok_i),
    .active_i    (active),
    .kick_i      (kick),
    .expire_i    (expire),
    .state_q_o   (state_q),
    .state_d_o   (state_d),
    .limit_o     (limit),
    .clr_o       (clr)
  );

  // Outputs registered from the next phase so they change with the phase register
  always_ff @(posedge clk) begin
    if (rst) begin
      rst_n_q <= 1'b0;
      bite_q  <= 1'b0;
    end else begin
      rst_n_q <= releases_reset(state_d);
      bite_q  <= (state_d == PH_BITE) && (state_q != PH_BITE);
    end
  end

  assign rst_n_o   = rst_n_q;
  assign wd_bite_o = bite_q;

  // R7
  bite_low_chk: assert property (@(posedge clk) disable iff (rst)
    wd_bite_o |-> !rst_n_o);

  // R7
  bite_single_chk: assert property (@(posedge clk) disable iff (rst)
    wd_bite_o |=> !wd_bite_o);

  // R2
  supply_loss_chk: assert property (@(posedge clk) disable iff (rst)
    !supply_ok_i |=> (!rst_n_o && !wd_bite_o));

  // R10
  wd_off_chk: assert property (@(posedge clk) disable iff (rst)
    wd_off_i |=> !wd_bite_o);

  // R1
  release_supply_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_o) |-> $past(supply_ok_i));

endmodule

// File: tb/test_wwdg_rstgen.sv
module test_wwdg_rstgen;
  localparam int TICK_DIV = 16;
  localparam int P_POR    = 3;
  localparam int P_LEAD   = 10;
  localparam int P_CLOSED = 4;
  localparam int P_OPEN   = 5;
  localparam int P_PULSE  = 3;
  localparam int P_MINLOW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic kick_n = 1'b1;
  logic supply_ok = 1'b0;
  logic wd_off = 1'b0;
  logic wd_run = 1'b1;
  logic rst_n, bite;

  int n_chk = 0;
  int n_fail = 0;
  int bite_cnt = 0;
  int low_cnt = 0;
  int div = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  wwdg_rstgen #(
    .SYNC_STAGES (2),
    .MIN_LOW_CYC (P_MINLOW),
    .POR_TICKS   (P_POR),
    .LEAD_TICKS  (P_LEAD),
    .CLOSED_TICKS(P_CLOSED),
    .OPEN_TICKS  (P_OPEN),
    .PULSE_TICKS (P_PULSE)
  ) i_wwdg_rstgen (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick),
    .kick_n_i    (kick_n),
    .supply_ok_i (supply_ok),
    .wd_off_i    (wd_off),
    .wd_run_i    (wd_run),
    .rst_n_o     (rst_n),
    .wd_bite_o   (bite)
  );

  // Timebase strobe and output monitor, both away from the active edge
  always @(negedge clk) begin
    if (div == TICK_DIV - 1) begin div <= 0; tick <= 1'b1; end
    else begin div <= div + 1; tick <= 1'b0; end
    if (!rst) begin
      if (!rst_n) low_cnt <= low_cnt + 1;
      if (bite)   bite_cnt <= bite_cnt + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail + 1);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
    if (n > 0) step();
  endtask

  // Starts just after a tick; finishes before the next one
  task automatic kick(input int w);
    repeat (2) step();
    kick_n = 1'b0;
    repeat (w) step();
    kick_n = 1'b1;
    repeat (4) step();
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int lead_ok_ticks();
    return P_LEAD - 1;
  endfunction

  // Full lead phase from an aligned start: high one tick before, low on the last
  task automatic expect_full_lead(input string tag);
    int b0;
    b0 = bite_cnt;
    wait_ticks(lead_ok_ticks());
    check({tag, " reset high before lead ends"}, int'(rst_n), 1);
    wait_ticks(1);
    check({tag, " reset low at lead end"}, int'(rst_n), 0);
    check({tag, " bite flag at lead end"}, int'(bite), 1);
    step();
    check({tag, " one bite counted"}, bite_cnt - b0, 1);
  endtask

  initial begin
    int b0, l0, j;
    void'($urandom(32'h0000_51ed));
    repeat (5) step();
    rst = 1'b0;
    step();
    // R11
    check("R11 reset output after rst", int'(rst_n), 0);
    check("R11 bite after rst", int'(bite), 0);
    repeat (20) step();
    // R2
    check("R2 held low without supply", int'(rst_n), 0);

    // R1: power-on delay
    wait_ticks(1);
    supply_ok = 1'b1;
    wait_ticks(P_POR - 1);
    check("R1 low before delay ends", int'(rst_n), 0);
    wait_ticks(1);
    check("R1 released after delay", int'(rst_n), 1);

    // R3 lead timeout, R7 flag width
    expect_full_lead("R3");
    check("R7 flag lasts one clock", int'(bite), 0);
    // R6 pulse length
    wait_ticks(P_PULSE - 1);
    check("R6 low during pulse", int'(rst_n), 0);
    wait_ticks(1);
    check("R6 released after pulse", int'(rst_n), 1);

    // R6 trigger inside a pulse is ignored
    wait_ticks(P_LEAD);
    check("R6 second lead bite", int'(rst_n), 0);
    wait_ticks(1);
    kick(8);
    wait_ticks(P_PULSE - 1);
    check("R6 pulse ends after kick", int'(rst_n), 1);
    expect_full_lead("R6 ignored kick");
    wait_ticks(P_PULSE);

    // R5 random valid triggers in the open window
    wait_ticks($urandom_range(P_LEAD - 2, 0));
    kick(8);
    b0 = bite_cnt; l0 = low_cnt;
    for (int it = 0; it < 8; it++) begin
      wait_ticks(P_CLOSED);
      j = $urandom_range(P_OPEN - 1, 0);
      wait_ticks(j);
      kick(8);
    end
    check("R5 no reset cycles in valid run", low_cnt - l0, 0);
    check("R5 no bite in valid run", bite_cnt - b0, 0);

    // R8 short pulses in the closed window are ignored
    wait_ticks(1);
    kick(2);
    wait_ticks(1);
    kick(P_MINLOW - 1);
    wait_ticks(P_CLOSED - 2);
    check("R8 short pulses ignored", low_cnt - l0, 0);
    check("R8 still running", int'(rst_n), 1);
    kick(P_MINLOW);

    // R4 trigger on the last closed tick
    b0 = bite_cnt;
    wait_ticks(P_CLOSED - 1);
    kick(8);
    check("R4 early trigger resets", int'(rst_n), 0);
    check("R4 early trigger flagged", bite_cnt - b0, 1);
    wait_ticks(P_PULSE);
    check("R6 pulse after early trigger", int'(rst_n), 1);

    // R5 missing trigger in the open window
    wait_ticks(2);
    kick(8);
    wait_ticks(P_CLOSED);
    wait_ticks(P_OPEN - 1);
    check("R5 high before open ends", int'(rst_n), 1);
    wait_ticks(1);
    check("R5 reset at open end", int'(rst_n), 0);
    check("R5 flag at open end", int'(bite), 1);
    wait_ticks(P_PULSE);

    // R9 halt entered from the closed window
    kick(8);
    wait_ticks(1);
    wd_run = 1'b0;
    b0 = bite_cnt; l0 = low_cnt;
    for (int it = 0; it < P_LEAD + 4; it++) begin
      wait_ticks(1);
      if ($urandom_range(1, 0) == 1) kick(8);
    end
    check("R9 no reset while halted", low_cnt - l0, 0);
    check("R9 no bite while halted", bite_cnt - b0, 0);
    wait_ticks(1);
    wd_run = 1'b1;
    expect_full_lead("R9 resume");
    wait_ticks(P_PULSE);

    // R10 disable entered from the open window
    kick(8);
    wait_ticks(P_CLOSED);
    wd_off = 1'b1;
    b0 = bite_cnt; l0 = low_cnt;
    for (int it = 0; it < 2 * P_LEAD; it++) begin
      wait_ticks(1);
      if ($urandom_range(2, 0) != 0) kick(8);
    end
    check("R10 no reset while off", low_cnt - l0, 0);
    check("R10 no bite while off", bite_cnt - b0, 0);
    wait_ticks(1);
    wd_off = 1'b0;
    expect_full_lead("R10 re-enable");
    wait_ticks(P_PULSE);

    // R2 supply loss in the open window
    kick(8);
    wait_ticks(P_CLOSED + 1);
    b0 = bite_cnt;
    supply_ok = 1'b0;
    step();
    check("R2 reset on supply loss", int'(rst_n), 0);
    wait_ticks(3);
    check("R2 stays low", int'(rst_n), 0);
    check("R2 no watchdog flag", bite_cnt - b0, 0);
    supply_ok = 1'b1;
    wait_ticks(P_POR - 1);
    check("R1 low before second delay ends", int'(rst_n), 0);
    wait_ticks(1);
    check("R1 released again", int'(rst_n), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule